// File: doc/BRIEF.md
# Zero-Suppressed Event Frame Packer

This block turns the hits that survive threshold suppression during one bunch crossing into a single bit-serial frame. While a crossing is open, hits (a channel number and an ADC sample) are collected into a small local store. An end-of-crossing strobe closes the crossing. The block then emits a frame, most significant bit first. The frame holds a 24-bit identity header (bunch number, then sensor number, then chip number), an optional occupancy field, and one 13-bit word per kept hit, in arrival order.

A two-bit policy input decides when the header and the occupancy field appear. A width bit chooses a 3-bit or 4-bit occupancy field. The field width also caps the number of hits a frame can hold. Hits arriving after the cap is reached are discarded. Each discard is reflected in a per-crossing overflow flag and in a saturating discard counter. The serial output uses a valid/ready handshake. The block drops `in_ready` for the whole time a frame is being sent, and the upstream stage must hold its hits until `in_ready` returns high.

Top module: `zsf_frame_packer`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`=0, `in_ready`=1, `ovf_flag`=0 and `drop_total`=0.
- R2: When a frame is emitted, it starts with 24 header bits, MSB first, in this order: `bunch_id`[11:0], `sensor_id`[7:0], `chip_id`[3:0]. These inputs are sampled on the edge that accepts `crossing_end`. The first header bit is valid right after that edge.
- R3: Each kept hit is sent as 13 bits, MSB first: `hit_chan`[6:0] followed by `hit_adc`[5:0]. Hits are sent in the order they were accepted, after the header and the occupancy field.
- R4: Policy code 1 always sends the header. If the crossing has no hits, the frame is the header only. Otherwise the header is followed by an occupancy field holding (kept hits − 1), then the hits.
- R5: Policy code 2 (and code 0, which behaves the same) always sends the header and an occupancy field holding the kept-hit count, so an empty crossing gives a frame with a zero field.
- R6: Policy code 3 sends nothing for an empty crossing. `out_valid` stays 0 and `in_ready` stays 1. A non-empty crossing gives the same frame as code 1.
- R7: With `size_wide`=0 the occupancy field is 3 bits. With `size_wide`=1 it is 4 bits.
- R8: The most hits kept per crossing are 8 (narrow) or 16 (wide) under codes 1 and 3, and 7 or 15 under codes 2 and 0. Later hits are discarded.
- R9: On each crossing close, `ovf_flag` is updated to 1 if that crossing discarded any hit and to 0 otherwise. It does not change at any other time.
- R10: `drop_total` increases by one for each discarded hit and stops at its all-ones value.
- R11: While `out_valid`=1 and `out_ready`=0, `out_bit` and `out_last` stay unchanged, and no bit is lost or repeated.
- R12: `in_ready` goes low on the edge that closes a crossing when a frame results, and returns high after the frame's last bit is accepted. While it is low, `hit_valid` and `crossing_end` are ignored.
- R13: `out_last` is 1 on the final bit of each frame and on no other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Header policy code (0..3) |
| size_wide | input | 1 | 1 selects the 4-bit occupancy field, 0 the 3-bit field |
| bunch_id | input | 12 | Bunch number for the crossing being closed |
| sensor_id | input | 8 | Sensor number |
| chip_id | input | 4 | Chip number |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_chan | input | 7 | Channel number of the hit |
| hit_adc | input | 6 | ADC sample of the hit |
| crossing_end | input | 1 | Closes the current crossing |
| in_ready | output | 1 | High when hits and crossing_end are accepted |
| out_valid | output | 1 | Serial bit available |
| out_ready | input | 1 | Downstream takes the bit |
| out_bit | output | 1 | Serial frame bit |
| out_last | output | 1 | Marks the final bit of a frame |
| ovf_flag | output | 1 | Last closed crossing discarded hits |
| drop_total | output | 16 | Saturating count of discarded hits |

## Verification
A wrong hit count or a bad store index would show up at the ports as a mis-sized occupancy field, a frame of the wrong length, or hit words that are swapped or stale. These errors appear within one frame of the crossing that caused them. A phase or bit-counter slip in the serialiser shifts every later field of the same frame, and the bit-by-bit frame comparison catches it at once. A fault in the discard logic shows on `ovf_flag` and `drop_total` on the edge right after the crossing closes. A fault in the stall logic or the end-of-frame logic shows as a lost, doubled or mislabelled bit, or as `in_ready` returning at the wrong time. Random stalls and junk input during busy periods bring these faults out.

// File: rtl/zsf_pkg.sv
// Shared constants and helpers for the zero-suppressed frame packer.
// Assumes the occupancy field is 3 or 4 bits, so at most 16 hits per frame.
package zsf_pkg;
    localparam int unsigned MAX_HITS = 16;
    localparam int unsigned CNT_W    = $clog2(MAX_HITS + 1);
    localparam int unsigned IDX_W    = $clog2(MAX_HITS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_SIZE = 2'd2,
        PH_HIT  = 2'd3
    } phase_e;

    // Policies 0 and 2 carry the raw count (header and size always sent).
    function automatic logic count_direct(input logic [1:0] pol);
        return (pol == 2'd0) || (pol == 2'd2);
    endfunction

    // Largest number of hits a frame may carry under the given policy/width.
    function automatic logic [CNT_W-1:0] hit_limit(input logic [1:0] pol, input logic wide);
        logic [CNT_W-1:0] base;
        base = wide ? CNT_W'(16) : CNT_W'(8);
        return count_direct(pol) ? base - CNT_W'(1) : base;
    endfunction
endpackage

// File: rtl/zsf_hit_collector.sv
// Collects the hits of one open crossing into a local store, enforces the
// per-policy hit cap, and keeps the overflow flag and discard counter.
// Assumes mode and size_wide are stable while a crossing is open, and that
// the store is not written while the serialiser reads it (accept is low then).
module zsf_hit_collector
    import zsf_pkg::*;
#(
    parameter int unsigned HIT_W  = 13,
    parameter int unsigned DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              hit_valid,
    input  logic [HIT_W-1:0]  hit_word,
    input  logic              crossing_end,
    input  logic [1:0]        mode,
    input  logic              wide,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIT_W-1:0]  rd_word,
    output logic [CNT_W-1:0]  cnt_final,
    output logic              close,
    output logic              ovf_flag,
    output logic [DROP_W-1:0] drop_total
);
    logic [HIT_W-1:0] store_q [MAX_HITS];
    logic [CNT_W-1:0] cnt;
    logic             drop_seen;
    logic             take, room, keep, drop;

    // Classify this cycle's hit as kept or discarded.
    always_comb begin
        take      = accept && hit_valid;
        room      = cnt < hit_limit(mode, wide);
        keep      = take && room;
        drop      = take && !room;
        close     = accept && crossing_end;
        cnt_final = cnt + CNT_W'(keep);
    end

    assign rd_word = store_q[rd_idx];

    // Hit store write; contents need no reset.
    always_ff @(posedge clk) begin
        if (keep) store_q[cnt[IDX_W-1:0]] <= hit_word;
    end

    // Occupancy count, per-crossing overflow tracking and discard counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            drop_seen  <= 1'b0;
            ovf_flag   <= 1'b0;
            drop_total <= '0;
        end else begin
            if (close) begin
                cnt       <= '0;
                drop_seen <= 1'b0;
                ovf_flag  <= drop_seen || drop;
            end else begin
                cnt <= cnt_final;
                if (drop) drop_seen <= 1'b1;
            end
            if (drop && (drop_total != '1)) drop_total <= drop_total + DROP_W'(1);
        end
    end

    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_HITS));
    a_r9_ovf_only_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        !close |=> $stable(ovf_flag));
    a_r10_drop_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (drop_total >= $past(drop_total)) && (drop_total != '0));
endmodule

// File: rtl/zsf_frame_serializer.sv
// Walks a closed crossing out as a bit stream: header, optional occupancy
// field, then hit words, every field MSB first. Latches the header, count and
// policy when started, so the inputs may change during emission. Hit words
// are read from the collector store by index.
module zsf_frame_serializer
    import zsf_pkg::*;
#(
    parameter int unsigned HDR_W = 24,
    parameter int unsigned HIT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic             wide,
    input  logic [HDR_W-1:0] hdr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [HIT_W-1:0] rd_word,
    output logic [IDX_W-1:0] rd_idx,
    output logic             busy,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_bit,
    output logic             out_last
);
    localparam int unsigned MAXF = (HDR_W > HIT_W) ? HDR_W : HIT_W;
    localparam int unsigned BC_W = $clog2(MAXF);

    phase_e           phase;
    logic [BC_W-1:0]  bit_cnt, size_top;
    logic [CNT_W-1:0] n_r;
    logic [IDX_W-1:0] hit_idx;
    logic [HDR_W-1:0] hdr_r, hdr_sh;
    logic [3:0]       size_r, size_sh;
    logic [HIT_W-1:0] hit_sh;
    logic             wide_r, has_size_r, step;
    logic             hdr_end, size_end, hit_end, last_hit;

    // Field-end detection and the current output bit.
    always_comb begin
        size_top = wide_r ? BC_W'(3) : BC_W'(2);
        hdr_end  = bit_cnt == BC_W'(HDR_W - 1);
        size_end = bit_cnt == size_top;
        hit_end  = bit_cnt == BC_W'(HIT_W - 1);
        last_hit = {1'b0, hit_idx} == (n_r - CNT_W'(1));
        hdr_sh   = hdr_r >> (BC_W'(HDR_W - 1) - bit_cnt);
        size_sh  = size_r >> (size_top - bit_cnt);
        hit_sh   = rd_word >> (BC_W'(HIT_W - 1) - bit_cnt);
        busy      = phase != PH_IDLE;
        out_valid = busy;
        step      = out_valid && out_ready;
        unique case (phase)
            PH_HDR:  begin out_bit = hdr_sh[0];  out_last = hdr_end && !has_size_r; end
            PH_SIZE: begin out_bit = size_sh[0]; out_last = size_end && (n_r == '0); end
            PH_HIT:  begin out_bit = hit_sh[0];  out_last = hit_end && last_hit; end
            default: begin out_bit = 1'b0;       out_last = 1'b0; end
        endcase
    end

    assign rd_idx = hit_idx;

    // Frame sequencing: latch on start, advance one bit per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            hit_idx    <= '0;
            n_r        <= '0;
            hdr_r      <= '0;
            size_r     <= '0;
            wide_r     <= 1'b0;
            has_size_r <= 1'b0;
        end else if (start) begin
            hdr_r      <= hdr;
            n_r        <= cnt;
            wide_r     <= wide;
            has_size_r <= count_direct(mode) || (cnt != '0);
            size_r     <= count_direct(mode) ? cnt[3:0] : 4'(cnt - CNT_W'(1));
            bit_cnt    <= '0;
            hit_idx    <= '0;
            phase      <= (mode == 2'd3 && cnt == '0) ? PH_IDLE : PH_HDR;
        end else if (step) begin
            bit_cnt <= bit_cnt + BC_W'(1);
            unique case (phase)
                PH_HDR: if (hdr_end) begin
                    bit_cnt <= '0;
                    phase   <= has_size_r ? PH_SIZE : PH_IDLE;
                end
                PH_SIZE: if (size_end) begin
                    bit_cnt <= '0;
                    phase   <= (n_r != '0) ? PH_HIT : PH_IDLE;
                end
                PH_HIT: if (hit_end) begin
                    bit_cnt <= '0;
                    hit_idx <= hit_idx + IDX_W'(1);
                    if (last_hit) phase <= PH_IDLE;
                end
                default: ;
            endcase
        end
    end

    a_r13_last_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last));
    a_r6_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        start && mode == 2'd3 && cnt == '0 |=> !out_valid);
    a_r12_last_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_last && out_ready |=> !busy);
endmodule

// File: rtl/zsf_frame_packer.sv
// Top of the zero-suppressed event frame packer. Joins the hit collector and
// the frame serialiser. The block takes input only while no frame is in flight.
// Assumes upstream holds its hits while in_ready is low.
module zsf_frame_packer
    import zsf_pkg::*;
#(
    parameter int unsigned BX_W   = 12,
    parameter int unsigned SEN_W  = 8,
    parameter int unsigned CHIP_W = 4,
    parameter int unsigned CH_W   = 7,
    parameter int unsigned ADC_W  = 6,
    parameter int unsigned DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              size_wide,
    input  logic [BX_W-1:0]   bunch_id,
    input  logic [SEN_W-1:0]  sensor_id,
    input  logic [CHIP_W-1:0] chip_id,
    input  logic              hit_valid,
    input  logic [CH_W-1:0]   hit_chan,
    input  logic [ADC_W-1:0]  hit_adc,
    input  logic              crossing_end,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_bit,
    output logic              out_last,
    output logic              ovf_flag,
    output logic [DROP_W-1:0] drop_total
);
    localparam int unsigned HDR_W = BX_W + SEN_W + CHIP_W;
    localparam int unsigned HIT_W = CH_W + ADC_W;

    logic             busy, close;
    logic [CNT_W-1:0] cnt_final;
    logic [IDX_W-1:0] rd_idx;
    logic [HIT_W-1:0] rd_word;

    assign in_ready = !busy;

    zsf_hit_collector #(.HIT_W(HIT_W), .DROP_W(DROP_W)) u_collect (
        .clk(clk), .rst_n(rst_n), .accept(in_ready), .hit_valid(hit_valid),
        .hit_word({hit_chan, hit_adc}), .crossing_end(crossing_end),
        .mode(mode), .wide(size_wide), .rd_idx(rd_idx), .rd_word(rd_word),
        .cnt_final(cnt_final), .close(close), .ovf_flag(ovf_flag),
        .drop_total(drop_total)
    );

    zsf_frame_serializer #(.HDR_W(HDR_W), .HIT_W(HIT_W)) u_serial (
        .clk(clk), .rst_n(rst_n), .start(close), .mode(mode), .wide(size_wide),
        .hdr({bunch_id, sensor_id, chip_id}), .cnt(cnt_final), .rd_word(rd_word),
        .rd_idx(rd_idx), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_bit(out_bit), .out_last(out_last)
    );

    a_r12_no_input_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ovf_flag));
endmodule

// File: tb/tb_zsf_frame_packer.sv
module tb_zsf_frame_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd1;
    logic        size_wide = 1'b0;
    logic [11:0] bunch_id = '0;
    logic [7:0]  sensor_id = '0;
    logic [3:0]  chip_id = '0;
    logic        hit_valid = 1'b0;
    logic [6:0]  hit_chan = '0;
    logic [5:0]  hit_adc = '0;
    logic        crossing_end = 1'b0;
    logic        in_ready, out_valid, out_bit, out_last, ovf_flag;
    logic        out_ready = 1'b0;
    logic [5:0]  drop_total;

    int errors = 0;
    int checks = 0;
    int exp_drop = 0;
    bit finished = 0;
    int chans [32];
    int adcs [32];
    bit exp_q [$];
    bit got_q [$];

    always #2 clk = ~clk;

    zsf_frame_packer #(.DROP_W(6)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .size_wide(size_wide),
        .bunch_id(bunch_id), .sensor_id(sensor_id), .chip_id(chip_id),
        .hit_valid(hit_valid), .hit_chan(hit_chan), .hit_adc(hit_adc),
        .crossing_end(crossing_end), .in_ready(in_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last),
        .ovf_flag(ovf_flag), .drop_total(drop_total)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_bits(input int val, input int width);
        for (int b = width - 1; b >= 0; b--) exp_q.push_back(bit'((val >> b) & 1));
    endtask

    // One crossing: drive n hits, close, check flags, then drain and compare.
    task automatic do_crossing(input int md, input int wd, input int n, input bit gaps);
        int lim, kept, dropped, bx, sn, cp, cyc, stalls, first_bad;
        bit direct, emit, done, last_ok, r;
        string tag;
        direct = (md == 0) || (md == 2);
        lim = (wd != 0 ? 16 : 8) - (direct ? 1 : 0);
        kept = (n < lim) ? n : lim;
        dropped = n - kept;
        bx = int'($urandom % 4096); sn = int'($urandom % 256); cp = int'($urandom % 16);
        for (int i = 0; i < n; i++) begin
            chans[i] = int'($urandom % 128);
            adcs[i] = int'($urandom % 64);
        end
        emit = !(md == 3 && kept == 0);
        exp_q.delete();
        got_q.delete();
        if (emit) begin
            push_bits(bx, 12); push_bits(sn, 8); push_bits(cp, 4);
            if (direct) push_bits(kept, wd != 0 ? 4 : 3);
            else if (kept > 0) push_bits(kept - 1, wd != 0 ? 4 : 3);
            for (int i = 0; i < kept; i++) begin
                push_bits(chans[i], 7); push_bits(adcs[i], 6);
            end
        end
        exp_drop = (exp_drop + dropped > 63) ? 63 : exp_drop + dropped;

        @(negedge clk);
        mode = 2'(md); size_wide = wd[0];
        for (int i = 0; i < n; i++) begin
            hit_valid = 1'b1; hit_chan = 7'(chans[i]); hit_adc = 6'(adcs[i]);
            @(negedge clk);
            if (gaps && ($urandom % 3 == 0)) begin
                hit_valid = 1'b0;
                @(negedge clk);
            end
        end
        hit_valid = 1'b0;
        bunch_id = 12'(bx); sensor_id = 8'(sn); chip_id = 4'(cp);
        crossing_end = 1'b1;
        @(negedge clk);
        crossing_end = 1'b0;
        mode = 2'($urandom); bunch_id = 12'($urandom);

        chk(ovf_flag == (dropped > 0), "R9 ovf_flag after close", int'(ovf_flag), int'(dropped > 0));
        chk(drop_total == 6'(exp_drop), "R10 drop_total", int'(drop_total), exp_drop);

        if (!emit) begin
            for (int k = 0; k < 3; k++) begin
                chk(!out_valid && in_ready, "R6 empty crossing silent", int'(out_valid), 0);
                @(negedge clk);
            end
            return;
        end

        chk(!in_ready, "R12 in_ready low during frame", int'(in_ready), 0);
        chk(out_valid, "R2 first header bit right after close", int'(out_valid), 1);
        done = 0; cyc = 0; stalls = 0; last_ok = 1;
        while (!done && cyc < 3000) begin
            r = ($urandom % 4) != 0;
            out_ready = r;
            if (out_valid && !r) stalls++;
            if (out_valid && r) begin
                got_q.push_back(out_bit);
                if (out_last != (got_q.size() == exp_q.size())) last_ok = 0;
                if (out_last) done = 1;
            end
            if (!in_ready && ($urandom % 6 == 0)) begin
                hit_valid = 1'b1; hit_chan = 7'($urandom); crossing_end = 1'($urandom);
            end else begin
                hit_valid = 1'b0; crossing_end = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        hit_valid = 1'b0; crossing_end = 1'b0; out_ready = 1'b0;
        chk(in_ready, "R12 in_ready back after last bit", int'(in_ready), 1);
        chk(last_ok, "R13 out_last only on final bit", int'(last_ok), 1);
        chk(got_q.size() == exp_q.size(), "R7 R8 frame length", got_q.size(), exp_q.size());
        first_bad = -1;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (first_bad < 0 && got_q[i] != exp_q[i]) first_bad = i;
        case (md)
            1: tag = "R2 R3 R4 R11 frame bits (first bad index)";
            3: tag = "R2 R3 R6 R11 frame bits (first bad index)";
            default: tag = "R2 R3 R5 R11 frame bits (first bad index)";
        endcase
        chk(first_bad < 0, tag, first_bad, -1);
        chk(drop_total == 6'(exp_drop), "R12 R10 junk while busy ignored", int'(drop_total), exp_drop);
    endtask

    initial begin
        void'($urandom(32'd12345));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
        chk(in_ready, "R1 reset in_ready", int'(in_ready), 1);
        chk(!ovf_flag, "R1 reset ovf_flag", int'(ovf_flag), 0);
        chk(drop_total == 0, "R1 reset drop_total", int'(drop_total), 0);
        // Directed corners.
        do_crossing(1, 0, 0, 0);   // R4 header only
        do_crossing(2, 0, 0, 0);   // R5 zero size field
        do_crossing(3, 1, 0, 0);   // R6 nothing sent
        do_crossing(1, 0, 8, 0);   // R8 exactly full, narrow
        do_crossing(2, 0, 8, 0);   // R8 one drop, narrow direct
        do_crossing(3, 1, 16, 1);  // R8 full wide
        do_crossing(2, 1, 18, 0);  // R8 wide direct, 3 drops
        do_crossing(0, 1, 3, 1);   // R5 code 0 alias
        do_crossing(1, 1, 20, 0);  // R8 overflow wide
        // Random crossings, enough to saturate the narrow drop counter (R10).
        for (int t = 0; t < 70; t++)
            do_crossing(int'($urandom % 4), int'($urandom % 2), int'($urandom % 21), 1'($urandom));
        chk(drop_total == 6'd63 || exp_drop < 63, "R10 saturation", int'(drop_total), exp_drop);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule